// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between an 8-bit processor core and the off-chip memory bus of a small microcontroller. The core hands it one request at a time: an access kind, a 16-bit address and an accumulator byte. The block then runs the matching bus cycle and answers with a single-clock done pulse. For reads, the byte returned arrives on the read data output at the same time. Code fetches and table reads from code space are steered either to the internal ROM or to the external bus. The choice depends on the external-access input and on the effective address. Data reads and writes always go off-chip.

An external cycle is a fixed sequence of four phases: address, setup, strobe and recovery. Each phase lasts a parameterised number of clocks. In the address phase the low address byte sits on the shared byte-wide port and the address-latch strobe is high, so that a latch outside the chip can capture it. The upper address byte sits on its own port for the whole cycle. Next, the shared port either drives the write data or is released for the memory to drive read data. One active-low strobe then marks the transfer: code read, data read or data write.

Data accesses use one of two pointer widths. A full 16-bit pointer reaches the whole 64 KB data space. A narrow 8-bit pointer supplies only the low byte, and the upper port keeps whatever it last carried.

Top module: `xbus_ctrl`

## Requirements
- R1: A code access (reqKind 00 fetch or 01 table read) whose effective address is below 0x1000 while eaIn is 1 is served internally. romRd is high for exactly one clock with romAddr equal to the effective address. No bus strobe or ALE is asserted. In the next clock done is 1 and rdData equals romData as it was during that romRd clock. Data accesses (reqKind 10 read, 11 write) never use the internal path.
- R2: Code accesses at effective addresses 0x1000 and above while eaIn is 1 run an external bus cycle. All code accesses run an external bus cycle while eaIn is 0.
- R3: An external cycle takes four phases of PHASE_CLKS clocks each, in the order address, setup, strobe, recovery, starting in the clock after acceptance. ale is 1 exactly during the address phase. done is 1 for exactly the one clock that follows recovery.
- R4: During the address phase the shared port is driven (adOe=1) with the low byte of the effective address. During a read cycle it is released (adOe=0) from setup through recovery.
- R5: codeRdN is 0 only during the strobe phase of an external code cycle. In that phase dataRdN and dataWrN stay 1.
- R6: dataRdN is 0 only during the strobe phase of a data read. dataWrN is 0 only during the strobe phase of a data write. codeRdN stays 1 in both cases.
- R7: In a data write, reqAcc is driven on the shared port with adOe=1 through the setup, strobe and recovery phases. The data is therefore present before dataWrN falls and is held after it rises.
- R8: For external code cycles and for data accesses with reqWide=1, addrHigh shows the effective address bits 15:8 from the address phase onward and holds them until the next such access. With reqWide=0 the effective address is {addrHigh, reqAddr[7:0]} and addrHigh does not change. Internal fetches never change addrHigh.
- R9: For a table read (reqKind 01) the effective address is reqAddr + reqAcc modulo 65536. This sum also decides between internal and external service.
- R10: Read data is taken from adIn at the clock edge that ends the strobe phase and is shown on rdData together with done. A write leaves rdData at its previous value.
- R11: reqValid is ignored while a cycle is in progress. It starts no extra cycle and changes no output of the running one.
- R12: After reset all strobes are 1, ale, adOe, romRd and done are 0, and addrHigh is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqKind | input | 2 | 00 fetch, 01 table read, 10 data read, 11 data write |
| reqWide | input | 1 | Data access pointer width: 1 = 16-bit, 0 = 8-bit |
| reqAddr | input | ADDR_W | Address, program counter or table base |
| reqAcc | input | DATA_W | Accumulator: table offset and write data |
| eaIn | input | 1 | External-access input; 1 enables internal ROM |
| done | output | 1 | One-clock completion pulse |
| rdData | output | DATA_W | Byte returned by the last read |
| romRd | output | 1 | Internal ROM read strobe |
| romAddr | output | ADDR_W | Internal ROM address |
| romData | input | DATA_W | Internal ROM data |
| adOut | output | DATA_W | Shared low address / data port, output value |
| adOe | output | 1 | Shared port output enable |
| adIn | input | DATA_W | Shared port, input value |
| addrHigh | output | ADDR_W-DATA_W | Upper address port |
| ale | output | 1 | Address-latch strobe |
| codeRdN | output | 1 | Active-low external code read strobe |
| dataRdN | output | 1 | Active-low external data read strobe |
| dataWrN | output | 1 | Active-low external data write strobe |

## Verification
The assertions assume a well-formed core. They expect it to raise reqValid only while no cycle is running, except for the deliberate extra request in the busy-request test. Under that condition the strobes are mutually exclusive and addrHigh is stable under any strobe. The stimulus waits for each done pulse and for one idle clock before it issues the next request. It then makes a single stray request in the middle of a data read to probe R11. adIn carries a valid byte only while a read strobe is low, so sampling at the wrong edge yields a visibly different value.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  // Access kinds decoded from the two request kind bits
  typedef enum logic [1:0] {
    KIND_FETCH  = 2'b00,
    KIND_TABLE  = 2'b01,
    KIND_DREAD  = 2'b10,
    KIND_DWRITE = 2'b11
  } xbusKind_e;

  // Bus cycle phases
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROM,
    PH_ADDR,
    PH_SETUP,
    PH_STROBE,
    PH_RECOVER
  } xbusPhase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;    // latch request, effective address, write byte
    logic capRom;     // capture internal ROM byte
    logic capBus;     // capture byte from the shared port
    logic driveAddr;  // put low address on the shared port
    logic driveData;  // put write byte on the shared port
  } xbusCtl_t;

endpackage

// File: rtl/xbus_ctrl_dp.sv
module xbus_ctrl_dp
  import xbus_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int INT_ROM_BYTES = 4096
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  xbusCtl_t                 ctl,
  input  logic [1:0]               reqKind,
  input  logic                     reqWide,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqAcc,
  input  logic                     eaIn,
  input  logic [DATA_W-1:0]        adIn,
  input  logic [DATA_W-1:0]        romData,
  output logic                     romHit,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic [ADDR_W-DATA_W-1:0] addrHigh,
  output logic [ADDR_W-1:0]        romAddr,
  output logic [DATA_W-1:0]        rdData
);

  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W:0] ROM_LIMIT = (ADDR_W + 1)'(INT_ROM_BYTES);

  xbusKind_e         kind;
  logic              isCode;
  logic              takesHigh;
  logic [ADDR_W-1:0] effAddr;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wrReg;
  logic [DATA_W-1:0] rdReg;
  logic [HI_W-1:0]   hiReg;

  assign kind = xbusKind_e'(reqKind);

  // Effective address and internal/external steering
  always_comb begin
    isCode = (kind == KIND_FETCH) || (kind == KIND_TABLE);
    unique case (kind)
      KIND_FETCH: effAddr = reqAddr;
      KIND_TABLE: effAddr = reqAddr + ADDR_W'(reqAcc);
      default:    effAddr = reqWide ? reqAddr : {hiReg, reqAddr[DATA_W-1:0]};
    endcase
    romHit    = isCode && eaIn && ({1'b0, effAddr} < ROM_LIMIT);
    takesHigh = isCode || reqWide;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      wrReg   <= '0;
      hiReg   <= '0;
    end else if (ctl.loadReq) begin
      addrReg <= effAddr;
      wrReg   <= reqAcc;
      if (!romHit && takesHigh) hiReg <= effAddr[ADDR_W-1:DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdReg <= '0;
    else if (ctl.capRom) rdReg <= romData;
    else if (ctl.capBus) rdReg <= adIn;
  end

  assign adOut    = ctl.driveData ? wrReg : addrReg[DATA_W-1:0];
  assign adOe     = ctl.driveAddr | ctl.driveData;
  assign addrHigh = hiReg;
  assign romAddr  = addrReg;
  assign rdData   = rdReg;

endmodule

// File: rtl/xbus_ctrl_fsm.sv
module xbus_ctrl_fsm
  import xbus_pkg::*;
#(
  parameter int PHASE_CLKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       romHit,
  output xbusCtl_t   ctl,
  output logic       ale,
  output logic       codeRdN,
  output logic       dataRdN,
  output logic       dataWrN,
  output logic       romRd,
  output logic       done
);

  localparam int CNT_W = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;

  xbusPhase_e phase;
  xbusPhase_e phaseNext;
  logic       lastClk;
  logic       doneNext;
  logic       isWriteReg;
  logic       isCodeReg;

  // Phase length counter, only when a phase spans more than one clock
  generate
    if (PHASE_CLKS > 1) begin : g_cnt
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   cnt <= '0;
        else if (phaseNext != phase) cnt <= '0;
        else if (phase != PH_IDLE)   cnt <= cnt + CNT_W'(1);
      end
      assign lastClk = (cnt == CNT_W'(PHASE_CLKS - 1));
    end else begin : g_nocnt
      assign lastClk = 1'b1;
    end
  endgenerate

  always_comb begin
    phaseNext = phase;
    ctl       = '0;
    ale       = 1'b0;
    codeRdN   = 1'b1;
    dataRdN   = 1'b1;
    dataWrN   = 1'b1;
    romRd     = 1'b0;
    doneNext  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          ctl.loadReq = 1'b1;
          phaseNext   = romHit ? PH_ROM : PH_ADDR;
        end
      end
      PH_ROM: begin
        romRd      = 1'b1;
        ctl.capRom = 1'b1;
        doneNext   = 1'b1;
        phaseNext  = PH_IDLE;
      end
      PH_ADDR: begin
        ale           = 1'b1;
        ctl.driveAddr = 1'b1;
        if (lastClk) phaseNext = PH_SETUP;
      end
      PH_SETUP: begin
        ctl.driveData = isWriteReg;
        if (lastClk) phaseNext = PH_STROBE;
      end
      PH_STROBE: begin
        ctl.driveData = isWriteReg;
        if (isWriteReg)     dataWrN = 1'b0;
        else if (isCodeReg) codeRdN = 1'b0;
        else                dataRdN = 1'b0;
        if (lastClk) begin
          ctl.capBus = !isWriteReg;
          phaseNext  = PH_RECOVER;
        end
      end
      PH_RECOVER: begin
        ctl.driveData = isWriteReg;
        if (lastClk) begin
          doneNext  = 1'b1;
          phaseNext = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      done       <= 1'b0;
      isWriteReg <= 1'b0;
      isCodeReg  <= 1'b0;
    end else begin
      phase <= phaseNext;
      done  <= doneNext;
      if (ctl.loadReq) begin
        isWriteReg <= (xbusKind_e'(reqKind) == KIND_DWRITE);
        isCodeReg  <= (xbusKind_e'(reqKind) == KIND_FETCH) ||
                      (xbusKind_e'(reqKind) == KIND_TABLE);
      end
    end
  end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int PHASE_CLKS    = 2,
  parameter int INT_ROM_BYTES = 4096
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [1:0]               reqKind,
  input  logic                     reqWide,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqAcc,
  input  logic                     eaIn,
  output logic                     done,
  output logic [DATA_W-1:0]        rdData,
  output logic                     romRd,
  output logic [ADDR_W-1:0]        romAddr,
  input  logic [DATA_W-1:0]        romData,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic [ADDR_W-DATA_W-1:0] addrHigh,
  output logic                     ale,
  output logic                     codeRdN,
  output logic                     dataRdN,
  output logic                     dataWrN
);

  xbusCtl_t ctl;
  logic     romHit;

  xbus_ctrl_fsm #(
    .PHASE_CLKS(PHASE_CLKS)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqKind (reqKind),
    .romHit  (romHit),
    .ctl     (ctl),
    .ale     (ale),
    .codeRdN (codeRdN),
    .dataRdN (dataRdN),
    .dataWrN (dataWrN),
    .romRd   (romRd),
    .done    (done)
  );

  xbus_ctrl_dp #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .INT_ROM_BYTES(INT_ROM_BYTES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqKind (reqKind),
    .reqWide (reqWide),
    .reqAddr (reqAddr),
    .reqAcc  (reqAcc),
    .eaIn    (eaIn),
    .adIn    (adIn),
    .romData (romData),
    .romHit  (romHit),
    .adOut   (adOut),
    .adOe    (adOe),
    .addrHigh(addrHigh),
    .romAddr (romAddr),
    .rdData  (rdData)
  );

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     done,
  input logic                     romRd,
  input logic                     adOe,
  input logic [ADDR_W-DATA_W-1:0] addrHigh,
  input logic                     ale,
  input logic                     codeRdN,
  input logic                     dataRdN,
  input logic                     dataWrN
);

  logic anyStrobe;
  assign anyStrobe = !codeRdN || !dataRdN || !dataWrN;

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!codeRdN, !dataRdN, !dataWrN}) <= 1);

  p_ale_drives_port_r4: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> adOe);

  p_no_ale_in_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> !ale);

  p_read_released_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!codeRdN || !dataRdN) |-> !adOe);

  p_write_driven_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dataWrN |-> adOe);

  p_write_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataWrN) |-> adOe);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !anyStrobe && !ale);

  p_rom_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    romRd |-> !anyStrobe && !ale);

  p_rom_done_r1: assert property (@(posedge clk) disable iff (!rstN)
    romRd |=> done);

  p_high_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> $stable(addrHigh));

endmodule

bind xbus_ctrl xbus_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .done    (done),
  .romRd   (romRd),
  .adOe    (adOe),
  .addrHigh(addrHigh),
  .ale     (ale),
  .codeRdN (codeRdN),
  .dataRdN (dataRdN),
  .dataWrN (dataWrN)
);

// File: tb/xbus_ctrl_bench.sv
`timescale 1ns/1ps
module xbus_ctrl_bench;

  localparam int P = 2;

  typedef struct packed {
    logic        ale;
    logic        codeRdN;
    logic        dataRdN;
    logic        dataWrN;
    logic        adOe;
    logic [7:0]  adOut;
    logic [7:0]  addrHigh;
    logic        romRd;
    logic [15:0] romAddr;
    logic        done;
    logic [7:0]  rdData;
  } expCyc_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'b00;
  logic        reqWide = 1'b0;
  logic [15:0] reqAddr = 16'h0000;
  logic [7:0]  reqAcc = 8'h00;
  logic        eaIn = 1'b1;
  logic        done;
  logic [7:0]  rdData;
  logic        romRd;
  logic [15:0] romAddr;
  logic [7:0]  romData;
  logic [7:0]  adOut;
  logic        adOe;
  logic [7:0]  adIn;
  logic [7:0]  addrHigh;
  logic        ale;
  logic        codeRdN;
  logic        dataRdN;
  logic        dataWrN;

  int          compared = 0;
  int          mismatched = 0;
  logic        running = 1'b0;
  logic        bad;
  logic [7:0]  expHigh = 8'h00;
  logic [7:0]  expRd = 8'h00;
  logic [7:0]  respVal = 8'h00;
  logic [7:0]  extMem [int];
  expCyc_t     expQ [$];

  always #10 clk = ~clk;

  function automatic logic [7:0] romFn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] codeFn(input logic [15:0] a);
    return 8'(a[7:0] + a[15:8] + 8'h11);
  endfunction

  function automatic logic [7:0] dataFn(input logic [15:0] a);
    return ~a[7:0] ^ a[15:8];
  endfunction

  // Environment: internal ROM and external memory response
  assign romData = romFn(romAddr);
  assign adIn    = (!codeRdN || !dataRdN) ? respVal : 8'hEE;

  xbus_ctrl #(
    .PHASE_CLKS(P)
  ) u_xbus_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqWide(reqWide), .reqAddr(reqAddr), .reqAcc(reqAcc), .eaIn(eaIn),
    .done(done), .rdData(rdData), .romRd(romRd), .romAddr(romAddr),
    .romData(romData), .adOut(adOut), .adOe(adOe), .adIn(adIn),
    .addrHigh(addrHigh), .ale(ale), .codeRdN(codeRdN), .dataRdN(dataRdN),
    .dataWrN(dataWrN)
  );

  function automatic expCyc_t idleCyc();
    expCyc_t c;
    c = '0;
    c.codeRdN  = 1'b1;
    c.dataRdN  = 1'b1;
    c.dataWrN  = 1'b1;
    c.addrHigh = expHigh;
    return c;
  endfunction

  task automatic chk(input string tag, input string nm,
                     input logic [15:0] got, input logic [15:0] exp);
    if (got !== exp) begin
      bad = 1'b1;
      $display("FAIL %s %s at %0t: got %0h expected %0h", tag, nm, $time, got, exp);
    end
  endtask

  task automatic compareCyc(input expCyc_t e);
    bad = 1'b0;
    chk("R3", "ale", 16'(ale), 16'(e.ale));
    chk("R4", "adOe", 16'(adOe), 16'(e.adOe));
    if (e.adOe) chk(e.ale ? "R4" : "R7", "adOut", 16'(adOut), 16'(e.adOut));
    chk("R1", "romRd", 16'(romRd), 16'(e.romRd));
    if (e.romRd) chk("R1", "romAddr", romAddr, e.romAddr);
    chk("R5", "codeRdN", 16'(codeRdN), 16'(e.codeRdN));
    chk("R6", "dataRdN", 16'(dataRdN), 16'(e.dataRdN));
    chk("R6", "dataWrN", 16'(dataWrN), 16'(e.dataWrN));
    chk("R8", "addrHigh", 16'(addrHigh), 16'(e.addrHigh));
    chk("R3", "done", 16'(done), 16'(e.done));
    if (e.done) chk("R10", "rdData", 16'(rdData), 16'(e.rdData));
    compared++;
    if (bad) mismatched++;
  endtask

  // Cycle-by-cycle comparison against the reference trace
  always @(negedge clk) begin
    expCyc_t e;
    if (rstN && running) begin
      if (expQ.size() != 0) e = expQ.pop_front();
      else                  e = idleCyc();
      compareCyc(e);
    end
  end

  // Issue one request and queue the expected per-clock trace
  task automatic doReq(input logic [1:0] kind, input logic [15:0] addr,
                       input logic [7:0] acc, input logic wide,
                       input logic ea, input logic poke);
    logic [15:0] eff;
    logic        internal;
    logic [7:0]  val;
    expCyc_t     c;
    @(posedge clk); #2;
    reqValid = 1'b1; reqKind = kind; reqAddr = addr;
    reqAcc = acc; reqWide = wide; eaIn = ea;
    case (kind)
      2'b00:   eff = addr;
      2'b01:   eff = addr + {8'h00, acc};
      default: eff = wide ? addr : {expHigh, addr[7:0]};
    endcase
    internal = (kind <= 2'b01) && ea && (eff < 16'h1000);
    if (kind == 2'b11)      val = acc;
    else if (internal)      val = romFn(eff);
    else if (kind <= 2'b01) val = codeFn(eff);
    else if (extMem.exists(int'(eff))) val = extMem[int'(eff)];
    else                    val = dataFn(eff);
    respVal = val;
    @(posedge clk); #2;
    reqValid = 1'b0;
    if (internal) begin
      c = idleCyc(); c.romRd = 1'b1; c.romAddr = eff; expQ.push_back(c);
      c = idleCyc(); c.done = 1'b1; c.rdData = val; expRd = val; expQ.push_back(c);
    end else begin
      if (kind <= 2'b01 || wide) expHigh = eff[15:8];
      for (int i = 0; i < 4 * P; i++) begin
        c = idleCyc();
        case (i / P)
          0: begin c.ale = 1'b1; c.adOe = 1'b1; c.adOut = eff[7:0]; end
          1: if (kind == 2'b11) begin c.adOe = 1'b1; c.adOut = acc; end
          2: begin
            if (kind == 2'b11) begin c.dataWrN = 1'b0; c.adOe = 1'b1; c.adOut = acc; end
            else if (kind <= 2'b01) c.codeRdN = 1'b0;
            else c.dataRdN = 1'b0;
          end
          default: if (kind == 2'b11) begin c.adOe = 1'b1; c.adOut = acc; end
        endcase
        expQ.push_back(c);
      end
      c = idleCyc(); c.done = 1'b1;
      if (kind == 2'b11) begin extMem[int'(eff)] = acc; c.rdData = expRd; end
      else begin c.rdData = val; expRd = val; end
      expQ.push_back(c);
    end
    if (poke) begin
      // R11: stray request in mid-cycle must not start anything
      repeat (2) @(posedge clk); #2;
      reqValid = 1'b1; reqKind = 2'b11; reqAddr = 16'hBEEF; reqWide = 1'b1;
      @(posedge clk); #2;
      reqValid = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    compared++;
    mismatched++;
    $display("FAIL watchdog: got no completion expected finish by %0t", $time);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #2;
    rstN = 1'b1;
    running = 1'b1;
    // R12: idle outputs and addrHigh 0x00 after reset
    repeat (3) @(posedge clk);
    // R8/R12: narrow read right after reset uses upper byte 0x00
    doReq(2'b10, 16'hAB55, 8'h00, 1'b0, 1'b1, 1'b0);
    // R1: internal fetches, including the top internal address
    doReq(2'b00, 16'h0123, 8'h00, 1'b0, 1'b1, 1'b0);
    doReq(2'b00, 16'h0FFF, 8'h00, 1'b0, 1'b1, 1'b0);
    // R2: first external address, and a low address with eaIn low
    doReq(2'b00, 16'h1000, 8'h00, 1'b0, 1'b1, 1'b0);
    doReq(2'b00, 16'h0010, 8'h00, 1'b0, 1'b0, 1'b0);
    // R9: table sums crossing the boundary, staying inside, wrapping
    doReq(2'b01, 16'h0F80, 8'h80, 1'b0, 1'b1, 1'b0);
    doReq(2'b01, 16'h0F00, 8'h7F, 1'b0, 1'b1, 1'b0);
    doReq(2'b01, 16'hFFF0, 8'h20, 1'b0, 1'b1, 1'b0);
    doReq(2'b01, 16'h4000, 8'h05, 1'b0, 1'b0, 1'b0);
    // R6/R7/R10: wide write then read back
    doReq(2'b11, 16'h2345, 8'hA5, 1'b1, 1'b1, 1'b0);
    doReq(2'b10, 16'h2345, 8'h00, 1'b1, 1'b1, 1'b0);
    // R8: narrow write and read inherit upper byte 0x23
    doReq(2'b11, 16'h0067, 8'h3C, 1'b0, 1'b1, 1'b0);
    doReq(2'b10, 16'h0067, 8'h00, 1'b0, 1'b1, 1'b0);
    // R8: internal fetch leaves addrHigh, narrow read still at 0x23xx
    doReq(2'b00, 16'h0200, 8'h00, 1'b0, 1'b1, 1'b0);
    doReq(2'b10, 16'h0067, 8'h00, 1'b0, 1'b1, 1'b0);
    // R1: data read at a low address is never internal
    doReq(2'b10, 16'h0200, 8'h00, 1'b1, 1'b1, 1'b0);
    // R11: request while busy is ignored
    doReq(2'b10, 16'h2345, 8'h00, 1'b1, 1'b1, 1'b1);
    repeat (4) @(posedge clk);
    // R11: the stray write must not have stored anything at 0xBEEF
    doReq(2'b10, 16'hBEEF, 8'h00, 1'b1, 1'b1, 1'b0);
    repeat (3) @(posedge clk);
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule